// File: doc/BRIEF.md
# SPI Master Serial Clock and Select Sequencer

This block drives the serial side of an SPI master for one peripheral. It holds one configuration word and takes 8-bit characters over a valid/ready stream. For each character it asserts the active-low select, waits a programmed lead time, produces eight serial clock periods derived from the system clock by an integer divider, shifts the character out MSB first on `mosi`, and shifts a received character in from `miso`. Between characters it can add a gap measured in multiples of 32 system clocks. After each character it either keeps the select asserted, releases it, or forces a release pulse of at least one serial period.

The transmit interface is valid/ready. A character is taken on a rising clock edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and not yet accepted, `tx_data` must stay stable. `tx_ready` is raised only at three points: when the sequencer is idle, when it is holding the select asserted, and at the cycle where it decides what follows a finished character. The receive side has no back-pressure. `rx_valid` is a one-cycle pulse with `rx_data`, and the consumer must take it in that cycle.

Top module: `spi_seq_top`

## Requirements
- R1: Configuration word layout (written with `cfg_we`): bits 31:24 gap count G, bits 23:16 lead count L, bits 15:8 divider D, bit 3 keep-select, bit 2 force-release, bit 1 capture-on-leading, bit 0 clock polarity; bits 7:4 are ignored. After reset the word is all zeros, `cs_n` is 1 and `sck` is 0.
- R2: While D is 0 or 1, `tx_ready` stays low, no character is accepted and `cs_n` stays high.
- R3: A serial period lasts D system clocks. A trailing edge follows its leading edge by floor(D/2) clocks, and the next leading edge follows that trailing edge by D-floor(D/2) clocks.
- R4: The first leading edge of a character comes L clocks after `cs_n` falls, or floor(D/2) clocks when L is 0. `sck` is at its idle level in the cycle `cs_n` falls.
- R5: With G nonzero and the select kept, the next character's first leading edge comes D-floor(D/2) + 32*G + (lead delay of R4) clocks after the previous last trailing edge.
- R6: With G zero, force-release clear and a character waiting at the last trailing edge, the next leading edge follows D-floor(D/2) clocks later. The select stays low and the serial clock keeps its duty cycle.
- R7: When no character is waiting and keep-select is clear, `cs_n` rises D-floor(D/2) + 32*G clocks after the last trailing edge, with `sck` idle. With keep-select set, `cs_n` stays low and `tx_ready` stays high until the next character.
- R8: With force-release set, `cs_n` goes high for at least D clocks between two characters, even when the second is already waiting.
- R9: The idle level of `sck` equals the polarity bit. The leading edge is the first edge away from idle. With capture-on-leading set, `miso` is sampled on leading edges and `mosi` changes on trailing edges, with bit 7 driven as the select falls. With it clear, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R10: Characters are 8 bits, MSB first in both directions. `rx_valid` is a single-cycle pulse, raised with `rx_data` in the cycle after the eighth sample.
- R11: A character is accepted only on a cycle with `tx_valid` and `tx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word |
| tx_valid | input | 1 | Transmit character valid |
| tx_ready | output | 1 | Sequencer can accept a character |
| tx_data | input | 8 | Transmit character |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received character |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low peripheral select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check, on every cycle, that no character is taken while the divider is below two, that the serial clock sits at its idle level whenever the select falls or rises, and that the receive pulse never lasts two cycles. Cycle distances cannot be checked that way. These are the lead time, the half-period split, the gap after a character, the release pulse width and the release time, and only the bench scenarios show them. A bench-side peripheral model in each clock mode shows the bit order and the data exchanged in both directions.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

  typedef struct packed {
    logic [7:0] gap;
    logic [7:0] lead;
    logic [7:0] div;
    logic       keep;
    logic       force_rel;
    logic       cap_lead;
    logic       cpol;
  } seq_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_TAIL, ST_GAP, ST_HOLD, ST_REL
  } seq_st_t;

  function automatic seq_cfg_t unpack_cfg(input logic [31:0] w);
    seq_cfg_t c;
    c.gap       = w[31:24];
    c.lead      = w[23:16];
    c.div       = w[15:8];
    c.keep      = w[3];
    c.force_rel = w[2];
    c.cap_lead  = w[1];
    c.cpol      = w[0];
    return c;
  endfunction

endpackage

// File: rtl/spi_seq_cfg.sv
`timescale 1ns/1ps
module spi_seq_cfg
  import spi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output seq_cfg_t    cfg
);

  logic unused_rsvd;
  assign unused_rsvd = ^wdata[7:4];

  // R1: word resets to zero, loads on write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= unpack_cfg(wdata);
  end

endmodule

// File: rtl/spi_seq_ctrl.sv
`timescale 1ns/1ps
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FLD_W     = 8,
  parameter int GAP_SCALE = 32,
  parameter int MIN_DIV   = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  seq_cfg_t cfg,
  input  logic     tx_valid,
  output logic     tx_ready,
  output logic     accept,
  output logic     cont,
  output logic     lead_ev,
  output logic     trail_ev,
  output logic     sck,
  output logic     cs_n
);

  localparam int CNT_W = $clog2(((1 << FLD_W) - 1) * GAP_SCALE + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic             sck_q, cs_q;

  logic [CNT_W-1:0] half1, half2, setup_n, gap_n, div_n;
  logic             cnt_last, sck_act, div_ok, last_trail, dec;

  logic unused_cap;
  assign unused_cap = cfg.cap_lead;

  assign div_n    = CNT_W'(cfg.div);
  assign half1    = CNT_W'(cfg.div >> 1);
  assign half2    = div_n - half1;
  assign setup_n  = (cfg.lead != '0) ? CNT_W'(cfg.lead) : half1;
  assign gap_n    = CNT_W'(cfg.gap) * CNT_W'(GAP_SCALE);
  assign div_ok   = cfg.div >= FLD_W'(MIN_DIV);
  assign cnt_last = (cnt == CNT_W'(1));
  assign sck_act  = sck_q ^ cfg.cpol;

  assign lead_ev    = cnt_last && ((st == ST_SETUP) || (st == ST_SHIFT && !sck_act));
  assign trail_ev   = cnt_last && (st == ST_SHIFT) && sck_act;
  assign last_trail = trail_ev && (bitn == BIT_W'(DATA_W - 1));
  assign dec        = cnt_last && ((st == ST_GAP) || (st == ST_TAIL && cfg.gap == '0));

  assign tx_ready = div_ok && ((st == ST_IDLE) || (st == ST_HOLD) ||
                               (dec && !cfg.force_rel) ||
                               (last_trail && cfg.gap == '0 && !cfg.force_rel));
  assign accept   = tx_valid && tx_ready;
  assign cont     = accept && last_trail;

  assign sck  = sck_q;
  assign cs_n = ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          sck_q <= cfg.cpol;
          if (accept) begin
            cs_q <= 1'b1;
            cnt  <= setup_n;
            st   <= ST_SETUP;
          end
        end
        ST_HOLD: begin
          if (accept) begin
            cnt <= setup_n;
            st  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_last) begin
            sck_q <= ~sck_q;
            cnt   <= half1;
            bitn  <= '0;
            st    <= ST_SHIFT;
          end else cnt <= cnt - 1'b1;
        end
        ST_SHIFT: begin
          if (cnt_last) begin
            sck_q <= ~sck_q;
            if (sck_act) begin
              cnt <= half2;
              if (bitn == BIT_W'(DATA_W - 1)) begin
                bitn <= '0;
                if (!cont) st <= ST_TAIL;
              end else bitn <= bitn + 1'b1;
            end else cnt <= half1;
          end else cnt <= cnt - 1'b1;
        end
        ST_TAIL, ST_GAP: begin
          if (dec) begin
            if (cfg.force_rel) begin
              cs_q <= 1'b0;
              cnt  <= div_n;
              st   <= ST_REL;
            end else if (accept) begin
              cnt <= setup_n;
              st  <= ST_SETUP;
            end else if (cfg.keep) begin
              st <= ST_HOLD;
            end else begin
              cs_q <= 1'b0;
              st   <= ST_IDLE;
            end
          end else if (cnt_last) begin
            cnt <= gap_n;
            st  <= ST_GAP;
          end else cnt <= cnt - 1'b1;
        end
        ST_REL: begin
          if (cnt_last) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_seq_shift.sv
`timescale 1ns/1ps
module spi_seq_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lead,
  input  logic              accept,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              mosi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  localparam int CC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [CC_W-1:0]   cc;
  logic              chg_ev, cap_ev;

  // R9: edge roles swap with the capture-on-leading bit
  assign chg_ev = cap_lead ? trail_ev : lead_ev;
  assign cap_ev = cap_lead ? lead_ev  : trail_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_data  <= '0;
      cc       <= '0;
      mosi     <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (accept) begin
        tx_sr <= tx_data;
        if (cap_lead) mosi <= tx_data[DATA_W-1];
      end else if (chg_ev) begin
        mosi  <= cap_lead ? tx_sr[DATA_W-2] : tx_sr[DATA_W-1];
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
      if (cap_ev) begin
        rx_sr <= {rx_sr[DATA_W-2:0], miso};
        if (cc == CC_W'(DATA_W - 1)) begin
          rx_data  <= {rx_sr[DATA_W-2:0], miso};
          rx_valid <= 1'b1;
          cc       <= '0;
        end else cc <= cc + 1'b1;
      end else if (accept) begin
        cc <= '0;
      end
    end
  end

endmodule

// File: rtl/spi_seq_top.sv
`timescale 1ns/1ps
module spi_seq_top
  import spi_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FLD_W     = 8,
  parameter int GAP_SCALE = 32,
  parameter int MIN_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  seq_cfg_t cfg_q;
  logic     accept, cont, lead_ev, trail_ev;

  spi_seq_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  spi_seq_ctrl #(
    .DATA_W    (DATA_W),
    .FLD_W     (FLD_W),
    .GAP_SCALE (GAP_SCALE),
    .MIN_DIV   (MIN_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .accept   (accept),
    .cont     (cont),
    .lead_ev  (lead_ev),
    .trail_ev (trail_ev),
    .sck      (sck),
    .cs_n     (cs_n)
  );

  logic unused_cont;
  assign unused_cont = cont;

  spi_seq_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_lead (cfg_q.cap_lead),
    .accept   (accept),
    .lead_ev  (lead_ev),
    .trail_ev (trail_ev),
    .tx_data  (tx_data),
    .miso     (miso),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

endmodule

// File: rtl/spi_seq_chk.sv
`timescale 1ns/1ps
module spi_seq_chk #(
  parameter int FLD_W   = 8,
  parameter int MIN_DIV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sck,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic [FLD_W-1:0] cfg_div,
  input logic             cpol
);

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |-> (cfg_div >= FLD_W'(MIN_DIV)));  // R2

  AST_SELECT_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (sck == cpol));  // R4

  AST_SELECT_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (sck == cpol));  // R7

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);  // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $stable(cpol) && $past(cs_n)) |-> (sck == cpol));  // R9

endmodule

bind spi_seq_top spi_seq_chk #(
  .FLD_W   (FLD_W),
  .MIN_DIV (MIN_DIV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sck      (sck),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .cfg_div  (cfg_q.div),
  .cpol     (cfg_q.cpol)
);

// File: tb/spi_seq_top_test.sv
`timescale 1ns/1ps
module spi_seq_top_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, tx_valid, tx_ready, rx_valid, sck, cs_n, mosi, miso;
  logic [31:0] cfg_wdata;
  logic [7:0]  tx_data, rx_data;

  spi_seq_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  // {cfg word, tx char, peripheral char}
  localparam logic [47:0] VEC [6] = '{
    {32'h0000_0400, 8'hA5, 8'h3C},
    {32'h0007_0501, 8'h81, 8'h7E},
    {32'h0000_0602, 8'h5A, 8'hC3},
    {32'h0003_0303, 8'hF0, 8'h0F},
    {32'h0000_0200, 8'h01, 8'h80},
    {32'h0001_FF02, 8'h96, 8'h69}
  };

  int total = 0, bad = 0;
  bit done = 0;

  // monitor and peripheral model state
  int cyc = 0, li = 0, ti = 0, nfall = 0, rx_cnt = 0;
  int t_csf = 0, t_csr = 0, last_hi = 0;
  int lead_t [32];
  int trail_t [32];
  logic pcs = 1'b1, psck = 1'b0, cpol_b = 1'b0, cap_b = 1'b0, is_lead;
  logic [7:0] sb = 8'h00, sl_in = 8'h00, sl_out = 8'h00, sl_got = 8'h00, rx_last = 8'h00;
  int sl_cnt = 0;

  assign miso = sl_out[7];

  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin
      last_hi = cyc - t_csr; t_csf = cyc; nfall++; li = 0; ti = 0;
      sl_out = sb; sl_cnt = 0;
    end
    if (!pcs && cs_n) t_csr = cyc;
    if (sck !== psck && !cs_n) begin
      is_lead = (sck != cpol_b);
      if (is_lead) begin if (li < 32) lead_t[li] = cyc; li++; end
      else begin if (ti < 32) trail_t[ti] = cyc; ti++; end
      if (is_lead == cap_b) begin
        sl_in = {sl_in[6:0], mosi}; sl_cnt++;
        if (sl_cnt == 8) begin sl_got = sl_in; sl_cnt = 0; end
      end else begin
        if (sl_cnt == 0) sl_out = sb; else sl_out = {sl_out[6:0], 1'b0};
      end
    end
    if (rx_valid) begin rx_last = rx_data; rx_cnt++; end
    pcs = cs_n; psck = sck;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input longint act, input longint lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic wcfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w; cpol_b = w[0]; cap_b = w[1];
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  task automatic wait_cs_high();
    while (!cs_n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nf0, r0, dv, h1, h2, nexp;
    bit rdy_seen;
    logic [31:0] cw;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; tx_valid = 1'b0; tx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 cs_n after reset", cs_n, 1);
    chk("R1 sck after reset", sck, 0);
    chk("R1 rx_valid after reset", rx_valid, 0);
    chk("R2 tx_ready with zero divider", tx_ready, 0);

    // R2: divider 0 then 1 refused
    for (int k = 0; k < 2; k++) begin
      wcfg({16'h0000, 8'(k), 8'h00});
      nf0 = nfall; rdy_seen = 0;
      @(negedge clk); tx_valid = 1'b1; tx_data = 8'hAA;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (tx_ready) rdy_seen = 1;
      end
      tx_valid = 1'b0;
      chk("R2 ready raised with illegal divider", rdy_seen, 0);
      chk("R2 select asserted with illegal divider", nfall - nf0, 0);
    end

    // vector table: one character per configuration
    for (int v = 0; v < 6; v++) begin
      cw = VEC[v][47:16];
      sb = VEC[v][7:0];
      wcfg(cw);
      dv = int'(cw[15:8]); h1 = dv / 2; h2 = dv - h1;
      nexp = (cw[23:16] != 0) ? int'(cw[23:16]) : h1;
      r0 = rx_cnt;
      send(VEC[v][15:8]);
      wait_rx(r0 + 1);
      wait_cs_high();
      @(negedge clk);
      chk("R9/R10 peripheral received char", sl_got, VEC[v][15:8]);
      chk("R10 rx_data", rx_last, sb);
      chk("R4 lead delay", lead_t[0] - t_csf, nexp);
      chk("R3 serial period", lead_t[1] - lead_t[0], dv);
      chk("R3 first half", trail_t[0] - lead_t[0], h1);
      chk("R7 release time", t_csr - trail_t[7], h2);
      chk("R9 idle level", sck, cpol_b);
      chk("R10 edge count", li, 8);
    end

    // R6: back-to-back, no gap
    sb = 8'h5A; wcfg(32'h0000_0400); nf0 = nfall; r0 = rx_cnt;
    send(8'h3E); send(8'hC1);
    wait_rx(r0 + 2); wait_cs_high(); @(negedge clk);
    chk("R6 single select window", nfall - nf0, 1);
    chk("R6 duty across boundary", lead_t[8] - trail_t[7], 2);
    chk("R6 second char", sl_got, 8'hC1);
    chk("R11 rx count", rx_cnt - r0, 2);

    // R5: gap of 2 units, lead 3
    wcfg(32'h0203_0400); nf0 = nfall; r0 = rx_cnt;
    send(8'h11); send(8'h22);
    wait_rx(r0 + 2); wait_cs_high(); @(negedge clk);
    chk("R5 gap before next char", lead_t[8] - trail_t[7], 2 + 64 + 3);
    chk("R7 release after gap", t_csr - trail_t[15], 2 + 64);
    chk("R5 select kept", nfall - nf0, 1);

    // R7: keep-select hold
    wcfg(32'h0000_0408); nf0 = nfall; r0 = rx_cnt;
    send(8'h44);
    wait_rx(r0 + 1);
    repeat (100) @(negedge clk);
    chk("R7 select held", cs_n, 0);
    chk("R11 ready while held", tx_ready, 1);
    wcfg(32'h0000_0400);
    send(8'h77);
    wait_rx(r0 + 2); wait_cs_high(); @(negedge clk);
    chk("R7 no new select window", nfall - nf0, 1);
    chk("R7 char after hold", sl_got, 8'h77);

    // R8: forced release with a pending char
    wcfg(32'h0000_0604); nf0 = nfall; r0 = rx_cnt;
    send(8'h99); send(8'h66);
    wait_rx(r0 + 2); wait_cs_high(); @(negedge clk);
    chk("R8 two select windows", nfall - nf0, 2);
    chk_ge("R8 release width", last_hi, 6);
    chk("R8 second char", sl_got, 8'h66);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule